// File: doc/BRIEF.md
# ADC power-up configuration sequencer

This block takes a dual-channel ADC from power-up to a configured state. Once the supplies are reported good, it holds the converter's hardware reset line inactive for a power-on delay. It then drives one reset pulse of bounded width and leaves a settling gap. After that it sends a short list of register writes over a three-wire serial port. The first write selects the converter's high-performance operation. Two more writes turn on high-frequency operation for channel A and channel B. These two are sent only when the configuration input was high at the moment the sequence started.

All delays are counted in system clocks and derived from a clock-frequency parameter. The width of the reset pulse is checked at elaboration and must lie between 10 ns and 1 µs. Each serial write is one frame: the select line is low for the whole frame, the serial clock is a divided copy of the system clock, and a data bit changes only when the serial clock falls. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level control or status signal. Dropping power-good aborts the sequence at any point, and raising it again starts the sequence over from the beginning.

Top module: `adc_boot_seq`

## Requirements
- R1: While rst_n is low, and afterwards until power-good is first sampled high, adc_rst, ser_clk, ser_dout, busy and done are all low and ser_sel_n is high.
- R2: busy rises one clock after the first rising clock edge that samples pwr_good high. adc_rst rises POR_CYC clocks after that edge, where POR_CYC = ceil(POWER_ON_NS·CLK_HZ/1e9) and the default delay is 1 ms.
- R3: The reset pulse on adc_rst lasts exactly RST_CYC clocks (100 ns by default). Elaboration fails if RST_CYC clocks come to less than 10 ns or more than 1 µs.
- R4: ser_sel_n first goes low GAP_CYC+1 clocks after adc_rst falls, where GAP_CYC is at least 100 ns worth of clocks.
- R5: Each frame holds ser_sel_n low for exactly 16 ser_clk periods and carries 16 bits, MSB first. The bits are an 8-bit register address in bits 15:8, followed by 8-bit data in bits 7:0.
- R6: ser_clk has a period of 2·SCLK_HALF clocks and is low while ser_sel_n is high. ser_dout holds steady for as long as ser_clk is high, so it may change only together with a falling edge of ser_clk.
- R7: The first frame writes data 0x03 to address 0x03. When hf_enable was low at start, it is the only frame.
- R8: When hf_enable was high at start, two more frames follow in this order: data 0x01 to address 0x4A, then data 0x01 to address 0x58.
- R9: Between consecutive frames, ser_sel_n stays high for 4·SCLK_HALF+1 clocks, which is at least two ser_clk periods.
- R10: busy falls on the same clock edge on which the last frame ends. done rises on that edge, and busy and done are never high together. done stays high for as long as pwr_good stays high.
- R11: One clock after pwr_good is sampled low, adc_rst, ser_clk, busy and done are low and ser_sel_n is high, whatever phase the sequence was in. Raising pwr_good again replays the whole timed sequence.
- R12: hf_enable is latched when the sequence starts. A change of hf_enable during the sequence has no effect on the number of frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supplies good; high starts the sequence, low aborts it |
| hf_enable | input | 1 | Request the two per-channel high-frequency writes |
| adc_rst | output | 1 | Active-high hardware reset to the converter |
| ser_sel_n | output | 1 | Active-low serial frame select |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dout | output | 1 | Serial data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All writes sent |

## Verification
Every timed result is due a fixed number of clocks after the first rising edge that samples pwr_good high. With the bench settings these are: busy one clock later, adc_rst POR_CYC clocks later, adc_rst low after RST_CYC more clocks, the first frame GAP_CYC+1 clocks after that, and each further frame 36·SCLK_HALF+1 clocks after the previous one. The bench changes inputs just after a falling edge and numbers each later falling edge from that point. It records the index at which each output edge appears and compares these indices with the values computed from the requirements. Abort behaviour is checked at the falling edge that directly follows the clock edge sampling pwr_good low.

// File: rtl/adc_boot_pkg.sv
package adc_boot_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_POR,
    PH_RST,
    PH_GAP,
    PH_LOAD,
    PH_SEND,
    PH_SPACE,
    PH_DONE
  } boot_phase_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } reg_write_t;

  localparam int unsigned MAX_WRITES = 3;
  localparam int unsigned FRAME_BITS = $bits(reg_write_t);

  // Fixed write list: entry 0 always, entries 1 and 2 only with the high-frequency option.
  function automatic reg_write_t write_entry(input logic [1:0] idx);
    reg_write_t w;
    case (idx)
      2'd0:    w = '{addr: 8'h03, data: 8'h03};
      2'd1:    w = '{addr: 8'h4A, data: 8'h01};
      default: w = '{addr: 8'h58, data: 8'h01};
    endcase
    return w;
  endfunction

  // Rounds up, so a requested minimum time is never shortened.
  function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                   input longint unsigned hz);
    return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/boot_phase_timer.sv
module boot_phase_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (expired) cnt_q <= '0;
    else              cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              ser_sel_n,
  output logic              ser_clk,
  output logic              ser_dout,
  output logic              last
);
  localparam int unsigned PER = 2 * HALF;
  localparam int unsigned DW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int unsigned BW  = $clog2(WORD_W);

  logic              active_q;
  logic [WORD_W-1:0] shreg_q;
  logic [DW-1:0]     dcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic              wrap;

  assign wrap      = (dcnt_q == DW'(PER - 1));
  assign last      = active_q && wrap && (bcnt_q == BW'(WORD_W - 1));
  assign ser_sel_n = !active_q;
  assign ser_clk   = active_q && (dcnt_q >= DW'(HALF));
  assign ser_dout  = active_q && shreg_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      shreg_q  <= '0;
      dcnt_q   <= '0;
      bcnt_q   <= '0;
    end else if (flush) begin
      active_q <= 1'b0;
      dcnt_q   <= '0;
      bcnt_q   <= '0;
    end else if (load && !active_q) begin
      active_q <= 1'b1;
      shreg_q  <= word;
      dcnt_q   <= '0;
      bcnt_q   <= '0;
    end else if (active_q) begin
      if (wrap) begin
        dcnt_q <= '0;
        if (last) begin
          active_q <= 1'b0;
          bcnt_q   <= '0;
        end else begin
          bcnt_q  <= bcnt_q + BW'(1);
          shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
        end
      end else begin
        dcnt_q <= dcnt_q + DW'(1);
      end
    end
  end
endmodule

// File: rtl/adc_boot_seq.sv
module adc_boot_seq
  import adc_boot_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 200_000_000,
  parameter longint unsigned POWER_ON_NS  = 1_000_000,
  parameter longint unsigned RST_PULSE_NS = 100,
  parameter longint unsigned SEN_GAP_NS   = 100,
  parameter int unsigned     SCLK_HALF    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic hf_enable,
  output logic adc_rst,
  output logic ser_sel_n,
  output logic ser_clk,
  output logic ser_dout,
  output logic busy,
  output logic done
);
  localparam int unsigned POR_CYC   = int'(ns_to_cycles(POWER_ON_NS, CLK_HZ));
  localparam int unsigned RST_CYC   = int'(ns_to_cycles(RST_PULSE_NS, CLK_HZ));
  localparam int unsigned GAP_CYC   = int'(ns_to_cycles(SEN_GAP_NS, CLK_HZ));
  localparam int unsigned SPACE_CYC = 4 * SCLK_HALF;
  localparam int unsigned MAX_AB    = (POR_CYC > RST_CYC) ? POR_CYC : RST_CYC;
  localparam int unsigned MAX_CD    = (GAP_CYC > SPACE_CYC) ? GAP_CYC : SPACE_CYC;
  localparam int unsigned MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);
  localparam int unsigned IW        = $clog2(MAX_WRITES);

  // Elaboration guards on the timing window.
  if ((64'(RST_CYC) * 64'd1_000_000_000 < 64'd10 * CLK_HZ) ||
      (64'(RST_CYC) * 64'd1_000_000_000 > 64'd1000 * CLK_HZ)) begin : g_bad_rst_pulse
    $error("reset pulse outside the 10 ns to 1 us window");
  end
  if (SCLK_HALF < 1 || POR_CYC < 1 || GAP_CYC < 1) begin : g_bad_timing
    $error("timing parameters must give at least one clock");
  end

  boot_phase_e   phase_q, phase_d;
  logic [IW-1:0] idx_q;
  logic          hf_q;
  logic [IW-1:0] last_idx;
  logic          tmr_run, tmr_exp;
  logic [TW-1:0] tmr_lim;
  logic          tx_load, tx_last;
  reg_write_t    tx_word;

  assign last_idx = hf_q ? IW'(MAX_WRITES - 1) : '0;

  always_comb begin
    tmr_run = 1'b0;
    tmr_lim = TW'(SPACE_CYC);
    case (phase_q)
      PH_POR:   begin tmr_run = 1'b1; tmr_lim = TW'(POR_CYC); end
      PH_RST:   begin tmr_run = 1'b1; tmr_lim = TW'(RST_CYC); end
      PH_GAP:   begin tmr_run = 1'b1; tmr_lim = TW'(GAP_CYC); end
      PH_SPACE: begin tmr_run = 1'b1; tmr_lim = TW'(SPACE_CYC); end
      default:  ;
    endcase
  end

  boot_phase_timer #(.TW(TW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .limit   (tmr_lim),
    .expired (tmr_exp)
  );

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_OFF:   if (pwr_good) phase_d = PH_POR;
      PH_POR:   if (tmr_exp)  phase_d = PH_RST;
      PH_RST:   if (tmr_exp)  phase_d = PH_GAP;
      PH_GAP:   if (tmr_exp)  phase_d = PH_LOAD;
      PH_LOAD:  phase_d = PH_SEND;
      PH_SEND:  if (tx_last)  phase_d = (idx_q == last_idx) ? PH_DONE : PH_SPACE;
      PH_SPACE: if (tmr_exp)  phase_d = PH_LOAD;
      default:  phase_d = phase_q;
    endcase
    if (!pwr_good) phase_d = PH_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      idx_q   <= '0;
      hf_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_OFF) begin
        idx_q <= '0;
        hf_q  <= hf_enable;
      end else if (phase_q == PH_SEND && tx_last) begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  assign tx_load = (phase_q == PH_LOAD);
  assign tx_word = write_entry(2'(idx_q));

  serial_frame_tx #(.WORD_W(FRAME_BITS), .HALF(SCLK_HALF)) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!pwr_good),
    .load      (tx_load),
    .word      (tx_word),
    .ser_sel_n (ser_sel_n),
    .ser_clk   (ser_clk),
    .ser_dout  (ser_dout),
    .last      (tx_last)
  );

  assign adc_rst = (phase_q == PH_RST);
  assign busy    = (phase_q != PH_OFF) && (phase_q != PH_DONE);
  assign done    = (phase_q == PH_DONE);

endmodule

// File: rtl/adc_boot_seq_chk.sv
module adc_boot_seq_chk
  import adc_boot_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 200_000_000,
  parameter longint unsigned POWER_ON_NS  = 1_000_000,
  parameter longint unsigned RST_PULSE_NS = 100,
  parameter longint unsigned SEN_GAP_NS   = 100,
  parameter int unsigned     SCLK_HALF    = 2
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic adc_rst,
  input logic ser_sel_n,
  input logic ser_clk,
  input logic ser_dout,
  input logic busy,
  input logic done
);
  localparam int unsigned POR_CYC = int'(ns_to_cycles(POWER_ON_NS, CLK_HZ));
  localparam int unsigned RST_CYC = int'(ns_to_cycles(RST_PULSE_NS, CLK_HZ));
  localparam int unsigned GAP_CYC = int'(ns_to_cycles(SEN_GAP_NS, CLK_HZ));
  localparam int unsigned SEL_MIN = 4 * SCLK_HALF;

  int unsigned pg_hi, rst_len, since_rst, sel_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_hi <= 0; rst_len <= 0; since_rst <= 0; sel_hi <= 0;
    end else begin
      pg_hi     <= !pwr_good ? 0 : (pg_hi == 32'hFFFF_FFFF ? pg_hi : pg_hi + 1);
      rst_len   <= adc_rst ? rst_len + 1 : 0;
      since_rst <= adc_rst ? 0 : (since_rst == 32'hFFFF_FFFF ? since_rst : since_rst + 1);
      sel_hi    <= !ser_sel_n ? 0 : (sel_hi == 32'hFFFF_FFFF ? sel_hi : sel_hi + 1);
    end
  end

  p_por_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rst) |-> pg_hi >= POR_CYC);
  p_pulse_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_rst |-> rst_len < RST_CYC);
  p_pulse_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(adc_rst) && pwr_good && $past(pwr_good)) |-> rst_len == RST_CYC);
  p_sel_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_sel_n) |-> since_rst >= GAP_CYC);
  p_clk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sel_n |-> !ser_clk);
  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));
  p_frame_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_sel_n) |-> sel_hi >= SEL_MIN);
  p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pwr_good) |=> done);
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!adc_rst && ser_sel_n && !ser_clk && !busy && !done));
endmodule

bind adc_boot_seq adc_boot_seq_chk #(
  .CLK_HZ       (CLK_HZ),
  .POWER_ON_NS  (POWER_ON_NS),
  .RST_PULSE_NS (RST_PULSE_NS),
  .SEN_GAP_NS   (SEN_GAP_NS),
  .SCLK_HALF    (SCLK_HALF)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_good  (pwr_good),
  .adc_rst   (adc_rst),
  .ser_sel_n (ser_sel_n),
  .ser_clk   (ser_clk),
  .ser_dout  (ser_dout),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_adc_boot_seq.sv
module test_adc_boot_seq;
  localparam int P = 100;   // 500 ns at 200 MHz
  localparam int R = 20;    // 100 ns
  localparam int G = 20;    // 100 ns
  localparam int H = 2;
  localparam int FRAME = 32 * H;
  localparam int STEP  = 36 * H + 1;

  logic clk = 0, rst_n = 0, pwr_good = 0, hf_enable = 0;
  logic adc_rst, ser_sel_n, ser_clk, ser_dout, busy, done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  adc_boot_seq #(
    .CLK_HZ(200_000_000), .POWER_ON_NS(500), .RST_PULSE_NS(100),
    .SEN_GAP_NS(100), .SCLK_HALF(H)
  ) i_adc_boot_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .hf_enable(hf_enable),
    .adc_rst(adc_rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dout(ser_dout), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Event record filled by capture()
  int ev_busy, ev_rst_rise, ev_rst_fall, ev_done, ev_busy_fall, n_frames;
  int fr_start[4], fr_bits[4], min_space, glitch, bad_period;
  logic [15:0] fr_word[4];

  task automatic capture(input int max_cyc, input int toggle_at);
    logic p_rst = 0, p_sel = 1, p_clk = 0, p_dat = 0, p_busy = 0;
    int last_rise = -1, sel_rise = 0, bits = 0;
    logic [15:0] word = 0;
    ev_busy = -1; ev_rst_rise = -1; ev_rst_fall = -1; ev_done = -1; ev_busy_fall = -1;
    n_frames = 0; min_space = 1 << 30; glitch = 0; bad_period = 0;
    for (int k = 0; k < 4; k++) begin fr_start[k] = -1; fr_bits[k] = 0; fr_word[k] = 0; end
    for (int i = 1; i <= max_cyc; i++) begin
      @(negedge clk);
      if (adc_rst && !p_rst && ev_rst_rise < 0) ev_rst_rise = i;
      if (!adc_rst && p_rst) ev_rst_fall = i;
      if (busy && !p_busy && ev_busy < 0) ev_busy = i;
      if (!busy && p_busy) ev_busy_fall = i;
      if (!ser_sel_n && p_sel) begin
        if (n_frames < 4) fr_start[n_frames] = i;
        if (n_frames > 0 && i - sel_rise < min_space) min_space = i - sel_rise;
        word = 0; bits = 0; last_rise = -1;
      end
      if (ser_clk && !p_clk) begin
        word = {word[14:0], ser_dout};
        bits++;
        if (last_rise >= 0 && i - last_rise != 2 * H) bad_period++;
        last_rise = i;
      end
      if (ser_clk && p_clk && ser_dout != p_dat) glitch++;
      if (ser_sel_n && ser_clk) glitch++;
      if (ser_sel_n && !p_sel) begin
        if (n_frames < 4) begin fr_word[n_frames] = word; fr_bits[n_frames] = bits; end
        n_frames++;
        sel_rise = i;
      end
      if (done && ev_done < 0) ev_done = i;
      p_rst = adc_rst; p_sel = ser_sel_n; p_clk = ser_clk; p_dat = ser_dout; p_busy = busy;
      if (i == toggle_at) hf_enable = ~hf_enable;
      if (done) break;
    end
  endtask

  task automatic power_down();
    @(negedge clk);
    pwr_good = 0;
    @(negedge clk);
    chk("R11", "adc_rst after power loss", adc_rst, 0);
    chk("R11", "ser_sel_n after power loss", ser_sel_n, 1);
    chk("R11", "busy/done after power loss", {busy, done}, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1", "outputs in reset", {adc_rst, ser_sel_n, ser_clk, ser_dout, busy, done}, 6'b010000);
    @(negedge clk); rst_n = 1;
    repeat (50) @(negedge clk);
    chk("R1", "outputs idle without power-good", {adc_rst, ser_sel_n, ser_clk, ser_dout, busy, done}, 6'b010000);
  endtask

  // Full boot; hf_start is the level at start, toggle_at flips hf_enable mid-run (R12)
  task automatic t_boot(input logic hf_start, input int toggle_at, input int exp_frames, input string tag);
    logic [15:0] exp_w [3] = '{16'h0303, 16'h4A01, 16'h5801};
    hf_enable = hf_start;
    pwr_good = 1;
    capture(3000, toggle_at);
    chk("R2", {tag, " busy rise index"}, ev_busy, 1);
    chk("R2", {tag, " reset rise index"}, ev_rst_rise, P + 1);
    chk("R3", {tag, " reset pulse width"}, ev_rst_fall - ev_rst_rise, R);
    chk("R4", {tag, " reset release to first select"}, fr_start[0] - ev_rst_fall, G + 1);
    chk("R7", {tag, " frame count"}, n_frames, exp_frames);
    for (int k = 0; k < exp_frames && k < 3; k++) begin
      chk("R5", {tag, " bits per frame"}, fr_bits[k], 16);
      chk(k == 0 ? "R7" : "R8", {tag, " frame word"}, fr_word[k], exp_w[k]);
      if (k > 0) chk("R9", {tag, " frame start spacing"}, fr_start[k] - fr_start[k-1], STEP);
    end
    if (exp_frames > 1) chk("R9", {tag, " select high between frames"}, min_space, 4 * H + 1);
    chk("R6", {tag, " data change while clock high"}, glitch, 0);
    chk("R6", {tag, " serial clock period errors"}, bad_period, 0);
    chk("R10", {tag, " done index"}, ev_done, fr_start[exp_frames-1] + FRAME);
    chk("R10", {tag, " busy fall index"}, ev_busy_fall, ev_done);
    repeat (20) @(negedge clk);
    chk("R10", {tag, " done held"}, {busy, done}, 2'b01);
  endtask

  task automatic t_abort_in_reset();
    pwr_good = 1;
    repeat (P + 5) @(negedge clk);
    chk("R11", "reset pulse active before abort", adc_rst, 1);
    power_down();
  endtask

  task automatic t_abort_in_frame();
    hf_enable = 1;
    pwr_good = 1;
    repeat (P + R + G + 2 + 10) @(negedge clk);
    chk("R11", "frame active before abort", ser_sel_n, 0);
    power_down();
    chk("R11", "serial clock idle after abort", ser_clk, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_boot(1'b0, 0, 1, "single");
    power_down();
    t_boot(1'b1, 0, 3, "hf");
    power_down();
    t_boot(1'b0, 30, 1, "late-hf R12");
    power_down();
    t_abort_in_reset();
    t_abort_in_frame();
    t_boot(1'b1, 0, 3, "restart R11");
    power_down();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule